// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-ported memory array and watches the two access ports, called left and right. Each cycle it compares the two addresses while both ports are enabled. When they point at the same word it picks a winner, pulls the active-low busy flag of the losing port low, and suppresses any write the losing port attempts. Reads are not touched: only the write strobe toward the array passes through this block. The write/read direction of either access plays no part in the decision.

Arrival order is measured in clock edges. A port that was enabled at the same address on the previous edge has been there longer than a port that just moved there, and it keeps the location. When neither side was present earlier, the left port wins by fixed priority. Once a loser is chosen it stays busy until the collision ends. The busy flag and the write gating follow the current inputs in the same cycle, so a colliding write is stopped in the cycle it appears.

A mode input picks between deciding and following. In master mode the block arbitrates and drives both busy flags. In follower mode both busy outputs are held high and the busy inputs become per-side write inhibits, so several arrays can share one master's decision.

Top module: `dpcol_arbiter`

## Requirements
- R1: With the mode input high (master), both busy outputs are 1 whenever either enable is 0 or the two addresses differ.
- R2: When a collision (both enables 1, addresses equal) begins and exactly one port was enabled at that same address in the previous cycle, the other (newly arriving) port's busy output goes to 0 and the earlier port's stays 1.
- R3: When a collision begins with neither port (or both ports) present at that address in the previous cycle, right busy is 0 and left busy is 1; the two busy outputs are never 0 together.
- R4: The write request inputs have no effect on either busy output.
- R5: A busy output that went to 0 stays at 0 for as long as the collision continues, and returns to 1 in the same cycle the collision ends.
- R6: In master mode a port whose busy output is 0 has its gated write held at 0, and the busy inputs have no effect.
- R7: With the mode input low (follower), both busy outputs are 1 and a busy input of 0 forces that side's gated write to 0.
- R8: When not inhibited, a side's gated write equals its enable AND its write request.
- R9: After reset, with no history, a collision present in the first cycle is treated as a simultaneous arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| isMaster | input | 1 | 1: arbitrate and drive busy; 0: follow busy inputs |
| leftEn | input | 1 | Left port enable |
| leftAddr | input | AW | Left port address |
| leftWr | input | 1 | Left write request |
| rightEn | input | 1 | Right port enable |
| rightAddr | input | AW | Right port address |
| rightWr | input | 1 | Right write request |
| leftBusyIn | input | 1 | Left write inhibit in follower mode, active low |
| rightBusyIn | input | 1 | Right write inhibit in follower mode, active low |
| leftBusyN | output | 1 | Left busy flag, active low |
| rightBusyN | output | 1 | Right busy flag, active low |
| leftWrGated | output | 1 | Left write strobe toward the array |
| rightWrGated | output | 1 | Right write strobe toward the array |

## Verification
The bench aims at the edge where a collision starts: one side parked and the other arriving (a design ignoring history would always flag the right side), both arriving together (a design without a tie rule would flag both or neither), and a winner moving while the loser follows it, which must keep the old loser busy. It toggles write requests during a held collision to catch arbitration that depends on direction, and it flips the mode mid-collision and drives busy inputs low in master mode to catch a design that leaks the inhibit inputs into master behaviour. A random phase on a four-word address range compares every output against a behavioural model each cycle.

// File: rtl/dpcol_pkg.sv
package dpcol_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  // datapath -> control: what the compare stage sees this cycle
  typedef struct packed {
    logic match;
    logic leftSettled;
    logic rightSettled;
  } seen_t;

  // control -> datapath: which write strobes to block
  typedef struct packed {
    logic blockLeft;
    logic blockRight;
  } gate_t;
endpackage

// File: rtl/dpcol_datapath.sv
module dpcol_datapath
  import dpcol_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lEn,
  input  logic [AW-1:0] lAddr,
  input  logic          lWr,
  input  logic          rEn,
  input  logic [AW-1:0] rAddr,
  input  logic          rWr,
  input  gate_t         gate,
  output seen_t         seen,
  output logic          lWrOk,
  output logic          rWrOk
);
  logic          prevLEn, prevREn;
  logic [AW-1:0] prevLAddr, prevRAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLEn   <= 1'b0;
      prevREn   <= 1'b0;
      prevLAddr <= '0;
      prevRAddr <= '0;
    end else begin
      prevLEn   <= lEn;
      prevREn   <= rEn;
      prevLAddr <= lAddr;
      prevRAddr <= rAddr;
    end
  end

  always_comb begin
    seen.match        = lEn && rEn && (lAddr == rAddr);
    seen.leftSettled  = lEn && prevLEn && (lAddr == prevLAddr);
    seen.rightSettled = rEn && prevREn && (rAddr == prevRAddr);
    lWrOk = lEn && lWr && !gate.blockLeft;
    rWrOk = rEn && rWr && !gate.blockRight;
  end

  // R8: an unblocked side passes its write request
  assert_pass_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate.blockLeft && lEn && lWr) |-> lWrOk);
endmodule

// File: rtl/dpcol_control.sv
module dpcol_control
  import dpcol_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  isMaster,
  input  seen_t seen,
  input  logic  lBusyIn,
  input  logic  rBusyIn,
  output gate_t gate,
  output logic  lBusyN,
  output logic  rBusyN
);
  owner_t owner, ownerNext;
  logic   flagLeft, flagRight;

  always_comb begin
    flagLeft  = 1'b0;
    flagRight = 1'b0;
    if (seen.match) begin
      unique case (owner)
        OWN_LEFT:  flagRight = 1'b1;
        OWN_RIGHT: flagLeft  = 1'b1;
        default: begin
          if (seen.rightSettled && !seen.leftSettled) flagLeft = 1'b1;
          else                                        flagRight = 1'b1;
        end
      endcase
    end
    if (!isMaster || !seen.match) ownerNext = OWN_NONE;
    else if (flagRight)           ownerNext = OWN_LEFT;
    else                          ownerNext = OWN_RIGHT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else        owner <= ownerNext;
  end

  always_comb begin
    if (isMaster) begin
      lBusyN          = !flagLeft;
      rBusyN          = !flagRight;
      gate.blockLeft  = flagLeft;
      gate.blockRight = flagRight;
    end else begin
      lBusyN          = 1'b1;
      rBusyN          = 1'b1;
      gate.blockLeft  = !lBusyIn;
      gate.blockRight = !rBusyIn;
    end
  end

  assert_never_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!lBusyN && !rBusyN));

  assert_hold_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!lBusyN && isMaster) ##1 (seen.match && isMaster) |-> !lBusyN);

  assert_hold_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rBusyN && isMaster) ##1 (seen.match && isMaster) |-> !rBusyN);

  assert_follower_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !isMaster |-> (lBusyN && rBusyN));
endmodule

// File: rtl/dpcol_arbiter.sv
module dpcol_arbiter
  import dpcol_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          isMaster,
  input  logic          leftEn,
  input  logic [AW-1:0] leftAddr,
  input  logic          leftWr,
  input  logic          rightEn,
  input  logic [AW-1:0] rightAddr,
  input  logic          rightWr,
  input  logic          leftBusyIn,
  input  logic          rightBusyIn,
  output logic          leftBusyN,
  output logic          rightBusyN,
  output logic          leftWrGated,
  output logic          rightWrGated
);
  seen_t seen;
  gate_t gate;

  dpcol_datapath #(.AW(AW)) u_datapath (
    .clk(clk), .rst_n(rst_n),
    .lEn(leftEn), .lAddr(leftAddr), .lWr(leftWr),
    .rEn(rightEn), .rAddr(rightAddr), .rWr(rightWr),
    .gate(gate), .seen(seen),
    .lWrOk(leftWrGated), .rWrOk(rightWrGated)
  );

  dpcol_control u_control (
    .clk(clk), .rst_n(rst_n), .isMaster(isMaster), .seen(seen),
    .lBusyIn(leftBusyIn), .rBusyIn(rightBusyIn),
    .gate(gate), .lBusyN(leftBusyN), .rBusyN(rightBusyN)
  );

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (isMaster && !(leftEn && rightEn && leftAddr == rightAddr)) |-> (leftBusyN && rightBusyN));

  assert_busy_blocks_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isMaster && !leftBusyN) |-> !leftWrGated);

  assert_busy_blocks_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isMaster && !rightBusyN) |-> !rightWrGated);

  assert_follower_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!isMaster && !rightBusyIn) |-> !rightWrGated);
endmodule

// File: tb/dpcol_arbiter_bench.sv
module dpcol_arbiter_bench;
  localparam int AW = 15;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic isMaster, leftEn, leftWr, rightEn, rightWr, leftBusyIn, rightBusyIn;
  logic [AW-1:0] leftAddr, rightAddr;
  logic leftBusyN, rightBusyN, leftWrGated, rightWrGated;
  int checks = 0, failures = 0;

  // reference model state
  int mOwn = 0;
  logic mPLE = 0, mPRE = 0;
  logic [AW-1:0] mPLA = '0, mPRA = '0;

  always #2 clk = ~clk;

  dpcol_arbiter #(.AW(AW)) u_dpcol_arbiter (
    .clk(clk), .rst_n(rst_n), .isMaster(isMaster),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWr(leftWr),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWr(rightWr),
    .leftBusyIn(leftBusyIn), .rightBusyIn(rightBusyIn),
    .leftBusyN(leftBusyN), .rightBusyN(rightBusyN),
    .leftWrGated(leftWrGated), .rightWrGated(rightWrGated)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one cycle: drive, compare against model, then advance the model at the edge
  task automatic step(input logic m, input logic le, input logic [AW-1:0] la, input logic lw,
                      input logic re, input logic [AW-1:0] ra, input logic rw,
                      input logic lbi, input logic rbi, input string req);
    logic match, lSet, rSet, bL, bR, eLB, eRB, inhL, inhR;
    @(negedge clk);
    isMaster = m; leftEn = le; leftAddr = la; leftWr = lw;
    rightEn = re; rightAddr = ra; rightWr = rw; leftBusyIn = lbi; rightBusyIn = rbi;
    #1;
    match = le && re && (la == ra);
    lSet = le && mPLE && (la == mPLA);
    rSet = re && mPRE && (ra == mPRA);
    bL = 0; bR = 0;
    if (match) begin
      if (mOwn == 1) bR = 1;
      else if (mOwn == 2) bL = 1;
      else if (rSet && !lSet) bL = 1;
      else bR = 1;
    end
    if (m) begin eLB = !bL; eRB = !bR; inhL = bL; inhR = bR; end
    else begin eLB = 1; eRB = 1; inhL = !lbi; inhR = !rbi; end
    chk(req, "leftBusyN", leftBusyN, eLB);
    chk(req, "rightBusyN", rightBusyN, eRB);
    chk(req, "leftWrGated", leftWrGated, le && lw && !inhL);
    chk(req, "rightWrGated", rightWrGated, re && rw && !inhR);
    @(posedge clk);
    mOwn = (!m || !match) ? 0 : (bR ? 1 : 2);
    mPLE = le; mPRE = re; mPLA = la; mPRA = ra;
  endtask

  initial begin
    #150000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    isMaster = 1; leftEn = 0; rightEn = 0; leftWr = 0; rightWr = 0;
    leftAddr = '0; rightAddr = '0; leftBusyIn = 1; rightBusyIn = 1;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R9: first cycle after reset, both already colliding -> tie, left wins
    step(1, 1, 15'h10, 1, 1, 15'h10, 1, 1, 1, "R9");
    chk("R9", "rightBusyN after reset tie", rightBusyN, 1'b0);
    step(1, 1, 15'h10, 1, 1, 15'h10, 1, 1, 1, "R5");
    // R1: different addresses, enable off
    step(1, 1, 15'h11, 1, 1, 15'h22, 1, 1, 1, "R1");
    step(1, 0, 15'h22, 1, 1, 15'h22, 1, 1, 1, "R1");
    // R2: right parked, left arrives -> left busy
    step(1, 0, 15'h00, 0, 1, 15'h33, 0, 1, 1, "R2");
    step(1, 1, 15'h33, 1, 1, 15'h33, 1, 1, 1, "R2");
    chk("R2", "left loses to parked right", leftBusyN, 1'b0);
    // R4: flip write requests during the collision
    step(1, 1, 15'h33, 0, 1, 15'h33, 1, 1, 1, "R4");
    step(1, 1, 15'h33, 1, 1, 15'h33, 0, 0, 0, "R6");
    // R5: right (winner) moves, left follows in same cycle: left stays busy
    step(1, 1, 15'h34, 1, 1, 15'h34, 1, 1, 1, "R5");
    chk("R5", "loser held across move", leftBusyN, 1'b0);
    step(1, 1, 15'h35, 1, 1, 15'h34, 1, 1, 1, "R5");
    chk("R5", "release on mismatch", leftBusyN, 1'b1);
    // R2 mirror: left parked, right arrives
    step(1, 1, 15'h40, 1, 0, 15'h00, 0, 1, 1, "R2");
    step(1, 1, 15'h40, 1, 1, 15'h40, 1, 1, 1, "R2");
    chk("R2", "right loses to parked left", rightBusyN, 1'b0);
    // R3: both arrive on the same edge
    step(1, 0, 15'h00, 0, 0, 15'h00, 0, 1, 1, "R3");
    step(1, 1, 15'h55, 1, 1, 15'h55, 1, 1, 1, "R3");
    chk("R3", "tie goes to left", rightBusyN, 1'b0);
    // R7: follower mode mid-collision
    step(0, 1, 15'h55, 1, 1, 15'h55, 1, 0, 1, "R7");
    step(0, 1, 15'h55, 1, 1, 15'h55, 1, 1, 0, "R7");
    step(0, 1, 15'h66, 1, 1, 15'h77, 1, 1, 1, "R8");
    // back to master while collision held: both settled -> left wins
    step(0, 1, 15'h60, 1, 1, 15'h60, 1, 1, 1, "R7");
    step(1, 1, 15'h60, 1, 1, 15'h60, 1, 1, 1, "R3");
    // random phase on a small address range
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, $urandom % 4 != 0, 15'($urandom % 4), 1'($urandom),
           $urandom % 4 != 0, 15'($urandom % 4), 1'($urandom),
           1'($urandom), 1'($urandom), "R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule